// File: doc/BRIEF.md
# Half-Wave Symmetric Sine Generator

This block converts a phase word into one sine sample per accepted phase. A read-only table holds only the positive half of the wave, 0° to 180°, as offset-binary magnitudes. The negative half is not stored. When the top phase bit is set, the stored value is bitwise inverted, which mirrors it about mid-scale.

The table read is a single synchronous read behind a read enable. This lets it map onto a block RAM. The inversion is applied only after that read register. The half-select bit is delayed through its own register by the same one cycle, so each inversion meets the sample it belongs to. The table contents are computed from a formula when the design is elaborated. An upstream phase source drives `phase_vld_i` and `phase_i`. A downstream consumer takes `sample_o` whenever `sample_vld_o` is high.

Top module: `halfwave_sine_gen`

## Requirements
- R1: `sample_vld_o` is high in the cycle after each clock edge at which `phase_vld_i` was high, and low after each edge at which `phase_vld_i` was low.
- R2: When phase bit PHASE_W-1 is 0, `sample_o` equals table entry k. Entry k = 2^(SAMPLE_W-1) + round((2^(SAMPLE_W-1)-1)·sin(π·k/2^ADDR_W)). With the defaults this is 32768 + round(32767·sin(π·k/1024)).
- R3: When phase bit PHASE_W-1 is 1, `sample_o` equals the bitwise inversion (XOR with all ones, 0xFFFF at the default width) of the entry R2 gives for the same k.
- R4: k is phase bits [PHASE_W-2 : PHASE_W-1-ADDR_W], which is bits [10:1] at the defaults. Lower phase bits have no effect on the sample.
- R5: While `phase_vld_i` is low, `sample_o` holds its last value.
- R6: `rst_ni` low clears `sample_vld_o` and the delayed half-select. The table contents and the last read value are kept, so after reset `sample_o` shows the last read entry without inversion.
- R7: Phases presented on consecutive cycles each yield their own sample one cycle later, with no bubble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| phase_vld_i | input | 1 | Phase word valid |
| phase_i | input | PHASE_W | Phase word |
| sample_o | output | SAMPLE_W | Sine sample, offset binary |
| sample_vld_o | output | 1 | Sample valid |

## Verification
Every result is due exactly one clock edge after the phase that caused it is accepted. This covers the sample value, its inversion and the valid flag. The bench drives inputs on the falling edge and checks on the next falling edge, which comes just after the single register stage. The hold and reset cases are checked on later falling edges with no new phase presented. This shows that the held value and the cleared valid flag last over several cycles.

// File: rtl/sine_pkg.sv
package sine_pkg;
  localparam real PI = 3.14159265358979;

  // Offset-binary half-wave entry: mid + (mid-1)*sin(pi*k/depth), rounded
  function automatic int half_entry(input int k, input int aw, input int sw);
    real amp;
    real ang;
    amp = real'((1 << (sw - 1)) - 1);
    ang = PI * real'(k) / real'(1 << aw);
    return (1 << (sw - 1)) + $rtoi(amp * $sin(ang) + 0.5);
  endfunction
endpackage

// File: rtl/sine_half_rom.sv
module sine_half_rom #(
  parameter int ADDR_W   = 10,
  parameter int SAMPLE_W = 16
) (
  input  logic                clk_i,
  input  logic                rd_en_i,
  input  logic [ADDR_W-1:0]   rd_addr_i,
  output logic [SAMPLE_W-1:0] rd_data_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [SAMPLE_W-1:0] mem_q [DEPTH];
  logic [SAMPLE_W-1:0] rd_data_q;

  initial begin
    for (int i = 0; i < DEPTH; i++)
      mem_q[i] = SAMPLE_W'(sine_pkg::half_entry(i, ADDR_W, SAMPLE_W));
  end

  // Unreset read register: keeps block RAM inference
  always_ff @(posedge clk_i) begin
    if (rd_en_i) rd_data_q <= mem_q[rd_addr_i];
  end

  assign rd_data_o = rd_data_q;
endmodule

// File: rtl/sine_sel_delay.sv
module sine_sel_delay (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vld_i,
  input  logic msb_i,
  output logic vld_o,
  output logic msb_o
);
  logic vld_q, msb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      msb_q <= 1'b0;
    end else begin
      vld_q <= vld_i;
      if (vld_i) msb_q <= msb_i;
    end
  end

  assign vld_o = vld_q;
  assign msb_o = msb_q;

  assert_msb_align_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_i |=> (msb_o == $past(msb_i)));
endmodule

// File: rtl/sine_half_fold.sv
module sine_half_fold #(
  parameter int SAMPLE_W = 16
) (
  input  logic [SAMPLE_W-1:0] data_i,
  input  logic                inv_i,
  output logic [SAMPLE_W-1:0] data_o
);
  for (genvar b = 0; b < SAMPLE_W; b++) begin : g_bit
    assign data_o[b] = data_i[b] ^ inv_i;
  end
endmodule

// File: rtl/halfwave_sine_gen.sv
module halfwave_sine_gen #(
  parameter int PHASE_W  = 12,
  parameter int ADDR_W   = 10,
  parameter int SAMPLE_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                phase_vld_i,
  input  logic [PHASE_W-1:0]  phase_i,
  output logic [SAMPLE_W-1:0] sample_o,
  output logic                sample_vld_o
);
  localparam int MSB     = PHASE_W - 1;
  localparam int ADDR_HI = PHASE_W - 2;

  logic [ADDR_W-1:0]   rd_addr;
  logic [SAMPLE_W-1:0] rd_data;
  logic                inv_q;

  assign rd_addr = phase_i[ADDR_HI -: ADDR_W];

  sine_half_rom #(.ADDR_W(ADDR_W), .SAMPLE_W(SAMPLE_W)) u_rom (
    .clk_i     (clk_i),
    .rd_en_i   (phase_vld_i),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data)
  );

  sine_sel_delay u_sel (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .vld_i  (phase_vld_i),
    .msb_i  (phase_i[MSB]),
    .vld_o  (sample_vld_o),
    .msb_o  (inv_q)
  );

  // Inversion strictly after the read register
  sine_half_fold #(.SAMPLE_W(SAMPLE_W)) u_fold (
    .data_i (rd_data),
    .inv_i  (inv_q),
    .data_o (sample_o)
  );

  assert_vld_lag_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_vld_i |=> sample_vld_o);
  assert_vld_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !phase_vld_i |=> !sample_vld_o);
  assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !phase_vld_i |=> $stable(sample_o));
endmodule

// File: tb/halfwave_sine_gen_tb_top.sv
`timescale 1ns/1ps
module halfwave_sine_gen_tb_top;
  localparam real PI_TB = 3.14159265358979;
  localparam int  NVEC  = 10;
  localparam logic [11:0] VEC_PHASE [NVEC] = '{
    12'h000, 12'h002, 12'h400, 12'h7FE, 12'h123,
    12'h800, 12'hC00, 12'hFFF, 12'h9A5, 12'h555
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pvld = 1'b0;
  logic [11:0] phase = '0;
  logic [15:0] sample;
  logic        svld;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  halfwave_sine_gen dut_i (
    .clk_i(clk), .rst_ni(rst_n), .phase_vld_i(pvld), .phase_i(phase),
    .sample_o(sample), .sample_vld_o(svld)
  );

  function automatic logic [15:0] entry(input int k);
    int t;
    t = 32768 + $rtoi(32767.0 * $sin(PI_TB * real'(k) / 1024.0) + 0.5);
    return t[15:0];
  endfunction

  function automatic logic [15:0] model(input logic [11:0] ph);
    logic [15:0] e;
    e = entry(int'(ph[10:1]));
    return ph[11] ? ~e : e;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send(input logic [11:0] ph);
    @(negedge clk); pvld = 1'b1; phase = ph;
    @(negedge clk); pvld = 1'b0;
  endtask

  initial begin
    logic [15:0] held;
    logic [15:0] a, b;
    repeat (3) @(negedge clk);
    check("R6 reset valid", {15'b0, svld}, 16'd0);
    rst_n = 1'b1;

    // Vector table: R2/R3/R4 values, R1 valid lag
    for (int i = 0; i < NVEC; i++) begin
      send(VEC_PHASE[i]);
      check(VEC_PHASE[i][11] ? "R3 inverted half" : "R2 direct half", sample, model(VEC_PHASE[i]));
      check("R1 valid one cycle after", {15'b0, svld}, 16'd1);
    end

    // R2 endpoints explicit: peak and mid-scale
    send(12'h400); check("R2 peak", sample, 16'hFFFF);
    send(12'h000); check("R2 zero", sample, 16'h8000);
    send(12'h800); check("R3 zero inverted", sample, 16'h7FFF);
    send(12'hC00); check("R3 trough", sample, 16'h0000);

    // R4: dropped low bit
    send(12'h246); a = sample;
    send(12'h247); b = sample;
    check("R4 low bit ignored", b, a);
    check("R4 address field", a, model(12'h246));

    // R5: hold while idle, R1 valid low
    send(12'h9A5); held = sample;
    repeat (5) @(negedge clk);
    check("R5 hold", sample, held);
    check("R1 valid low idle", {15'b0, svld}, 16'd0);

    // R7: back-to-back
    @(negedge clk); pvld = 1'b1; phase = 12'h100;
    @(negedge clk); check("R7 b2b 0", sample, model(12'h100)); phase = 12'hA00;
    @(negedge clk); check("R7 b2b 1", sample, model(12'hA00)); phase = 12'h3FE;
    @(negedge clk); check("R7 b2b 2", sample, model(12'h3FE));
    check("R7 valid kept", {15'b0, svld}, 16'd1);
    pvld = 1'b0;
    @(negedge clk);

    // R6: reset clears inversion and valid, table value kept
    send(12'h900);
    check("R6 pre-reset", sample, model(12'h900));
    rst_n = 1'b0;
    @(negedge clk);
    check("R6 valid cleared", {15'b0, svld}, 16'd0);
    check("R6 half-select cleared", sample, entry(int'(10'h080)));
    rst_n = 1'b1;
    send(12'h900);
    check("R6 after reset", sample, model(12'h900));

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule